// File: doc/BRIEF.md
# ATA PIO Strobe Timing Generator

This block shapes the timing of programmed-I/O accesses on one ATA channel with two attached drives. Each access request runs three timed phases: an address phase held for the setup clocks, a strobe phase held for the active clocks, and a recovery gap before the next access. A one-clock completion pulse ends each access. Clock counts come from small coded fields that software writes through a byte-wide register write port. Every drive has its own timing byte. Setup time is held either per drive or in one register that both drives share.

The state machine has four states. PH_IDLE waits for a request. PH_SETUP drives the address phase. PH_ACTIVE drives the strobe. PH_RECOVER keeps the block busy with both outputs low. The transitions are:
- PH_IDLE to PH_SETUP when a request is accepted.
- PH_SETUP to PH_ACTIVE when the setup count runs out.
- PH_ACTIVE to PH_RECOVER when the active count runs out.
- PH_RECOVER to PH_IDLE when the recovery count runs out. The completion pulse is raised on this transition.

A request is sampled only in PH_IDLE, and that includes the cycle that carries the completion pulse. Holding the request high therefore produces back-to-back accesses.

The parameter `SHARED_SETUP` selects one of two setup variants:
- Value 0 is the per-drive variant. Each drive has its own setup register, and every access uses the longer of the two decoded setup times.
- Value 1 is the shared variant. One setup register serves both drives.

Top module: `pio_strobe_timer`

## Requirements
- R1: After reset, `addr_phase`, `strobe`, `busy`, `done` and `irq_pending` are low. All timing bytes reset to 0x00, which gives 16 active and 16 recovery clocks. All setup codes reset to 2'b11, which gives 5 setup clocks.
- R2: A request is accepted only when the block is idle, including the cycle that carries `done`. A request raised while `busy` is high is ignored. A request held high starts a new access on the clock after each `done`.
- R3: After acceptance, `addr_phase` is high for the decoded setup count. The setup code sits in bits 7:6 of a setup register and decodes as 2'b01=2, 2'b10=3, 2'b00=4, 2'b11=5 clocks.
- R4: `strobe` is high for the active count, which is held in bits 7:4 of the selected drive's timing byte. A value of 1..15 gives that many clocks, and 0 gives 16 clocks.
- R5: After the strobe, the recovery phase (`busy` high, `addr_phase` and `strobe` low) lasts for the count coded in bits 3:0 of the timing byte. Code 15 gives 1 clock, codes 1..14 give 2..15 clocks, and code 0 gives 16 clocks.
- R6: The phases always run in the order address, then strobe, then recovery, with no gaps between them. `done` is high for exactly one clock, the first idle clock after recovery, and `busy` is low in that clock.
- R7: `drv_sel` sampled at acceptance chooses the timing byte: 0 selects address 0, and 1 selects address 1.
- R8: With `SHARED_SETUP`=0, drive 0 has its setup register at address 2 and drive 1 at address 3. Every access uses the larger of the two decoded setup counts, whichever drive is selected.
- R9: With `SHARED_SETUP`=1, the one setup register is at address 2 and serves both drives. Writes to address 3 have no effect.
- R10: `irq_pending` is set by `irq_event`. A write to address 2 with bit 4 set clears it. A write to address 2 with bit 4 clear leaves it unchanged, as does a write to any other address. If a set and a clear happen in the same cycle, the set wins.
- R11: Register writes made during an access do not change that access. They take effect from the next accepted access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register address (0,1 timing bytes; 2,3 setup registers) |
| cfg_wdata | input | 8 | Register write data |
| irq_event | input | 1 | Sets the pending flag |
| req | input | 1 | Access request |
| drv_sel | input | 1 | Drive selected for the access |
| addr_phase | output | 1 | High during the address setup phase |
| strobe | output | 1 | High during the active strobe phase |
| busy | output | 1 | High from acceptance until the end of recovery |
| done | output | 1 | One-clock completion pulse |
| irq_pending | output | 1 | Interrupt pending flag |

## Verification
The embedded properties check the following on every cycle:
- The address phase only ever starts from idle.
- The strobe only ever follows the address phase.
- At least one recovery clock follows every strobe.
- The completion pulse lasts a single clock and comes straight out of recovery.
- A setup write with bit 4 clear keeps the pending flag.

Some behaviour can only be shown by the bench's scenarios, each compared clock by clock against a behavioural model on both setup variants:
- The exact phase lengths for each nibble code, including the 0-means-16 and 15-means-1 ends.
- Selection of the slower drive's setup time.
- Writes to the shared variant's unused address being ignored.
- Back-to-back accesses under a held request.
- Immunity of a running access to register writes.

// File: rtl/pio_timer_pkg.sv
package pio_timer_pkg;

    localparam int NUM_DRV   = 2;
    localparam int DRV_W     = $clog2(NUM_DRV);
    localparam int TIM_W     = 8;
    localparam int NIB_W     = 4;
    localparam int CNT_W     = NIB_W + 1;
    localparam int ADDR_W    = 2;
    localparam int SU_CODE_W = 2;
    localparam int SU_LSB    = 6;
    localparam int PEND_BIT  = 4;

    localparam logic [ADDR_W-1:0] A_TIM0 = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] A_SU0  = ADDR_W'(2);
    localparam logic [ADDR_W-1:0] A_SU1  = ADDR_W'(3);

    localparam logic [SU_CODE_W-1:0] SU_RESET = '1;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_SETUP,
        PH_ACTIVE,
        PH_RECOVER
    } phase_t;

    // Active nibble: zero stands for the full nibble range.
    function automatic logic [CNT_W-1:0] active_clocks(input logic [NIB_W-1:0] code);
        return (code == '0) ? CNT_W'(1 << NIB_W) : CNT_W'(code);
    endfunction

    // Recovery nibble: all-ones is the one-clock minimum, zero the maximum,
    // others are offset by one.
    function automatic logic [CNT_W-1:0] recover_clocks(input logic [NIB_W-1:0] code);
        if (code == '1)
            return CNT_W'(1);
        else if (code == '0)
            return CNT_W'(1 << NIB_W);
        else
            return CNT_W'(code) + CNT_W'(1);
    endfunction

    function automatic logic [CNT_W-1:0] setup_clocks(input logic [SU_CODE_W-1:0] code);
        logic [CNT_W-1:0] n;
        unique case (code)
            2'b01:   n = CNT_W'(2);
            2'b10:   n = CNT_W'(3);
            2'b00:   n = CNT_W'(4);
            default: n = CNT_W'(5);
        endcase
        return n;
    endfunction

endpackage

// File: rtl/pio_cfg_regs.sv
module pio_cfg_regs
    import pio_timer_pkg::*;
#(
    parameter bit SHARED_SETUP = 1'b0
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             we,
    input  logic [ADDR_W-1:0]                addr,
    input  logic [TIM_W-1:0]                 wdata,
    input  logic                             irq_event,
    output logic [NUM_DRV-1:0][TIM_W-1:0]    timing_o,
    output logic [CNT_W-1:0]                 setup_clks_o,
    output logic                             pending_o
);

    logic [TIM_W-1:0] tim_q [NUM_DRV];
    logic             pend_q;

    for (genvar g = 0; g < NUM_DRV; g++) begin : g_tim
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                tim_q[g] <= '0;
            else if (we && addr == (A_TIM0 + ADDR_W'(g)))
                tim_q[g] <= wdata;
        end
        assign timing_o[g] = tim_q[g];
    end

    if (SHARED_SETUP) begin : g_shared
        logic [SU_CODE_W-1:0] su_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                su_q <= SU_RESET;
            else if (we && addr == A_SU0)
                su_q <= wdata[SU_LSB +: SU_CODE_W];
        end
        assign setup_clks_o = setup_clocks(su_q);
    end else begin : g_per_drive
        logic [SU_CODE_W-1:0] su0_q, su1_q;
        logic [CNT_W-1:0]     n0, n1;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                su0_q <= SU_RESET;
                su1_q <= SU_RESET;
            end else if (we) begin
                if (addr == A_SU0) su0_q <= wdata[SU_LSB +: SU_CODE_W];
                if (addr == A_SU1) su1_q <= wdata[SU_LSB +: SU_CODE_W];
            end
        end
        assign n0 = setup_clocks(su0_q);
        assign n1 = setup_clocks(su1_q);
        assign setup_clks_o = (n0 > n1) ? n0 : n1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            pend_q <= 1'b0;
        else if (irq_event)
            pend_q <= 1'b1;
        else if (we && addr == A_SU0 && wdata[PEND_BIT])
            pend_q <= 1'b0;
    end
    assign pending_o = pend_q;

    assert_pending_kept_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_q && we && addr == A_SU0 && !wdata[PEND_BIT]) |=> pend_q);

    assert_event_sets_R10: assert property (@(posedge clk) disable iff (!rst_n)
        irq_event |=> pend_q);

endmodule

// File: rtl/pio_phase_fsm.sv
module pio_phase_fsm
    import pio_timer_pkg::*;
(
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          req,
    input  logic [DRV_W-1:0]              drv_sel,
    input  logic [NUM_DRV-1:0][TIM_W-1:0] timing,
    input  logic [CNT_W-1:0]              setup_clks,
    output logic                          addr_phase,
    output logic                          strobe,
    output logic                          busy,
    output logic                          done
);

    phase_t           state;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] act_q, rec_q;
    logic             done_q;
    logic [TIM_W-1:0] sel_tim;

    assign sel_tim = timing[drv_sel];

    // State register with phase counter; timing snapshotted at acceptance.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= PH_IDLE;
            cnt    <= '0;
            act_q  <= '0;
            rec_q  <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            unique case (state)
                PH_IDLE: begin
                    if (req) begin
                        state <= PH_SETUP;
                        cnt   <= setup_clks - CNT_W'(1);
                        act_q <= active_clocks(sel_tim[TIM_W-1 -: NIB_W]);
                        rec_q <= recover_clocks(sel_tim[NIB_W-1:0]);
                    end
                end
                PH_SETUP: begin
                    if (cnt == '0) begin
                        state <= PH_ACTIVE;
                        cnt   <= act_q - CNT_W'(1);
                    end else begin
                        cnt <= cnt - CNT_W'(1);
                    end
                end
                PH_ACTIVE: begin
                    if (cnt == '0) begin
                        state <= PH_RECOVER;
                        cnt   <= rec_q - CNT_W'(1);
                    end else begin
                        cnt <= cnt - CNT_W'(1);
                    end
                end
                PH_RECOVER: begin
                    if (cnt == '0) begin
                        state  <= PH_IDLE;
                        done_q <= 1'b1;
                    end else begin
                        cnt <= cnt - CNT_W'(1);
                    end
                end
            endcase
        end
    end

    // Outputs decoded from the state.
    always_comb begin
        addr_phase = 1'b0;
        strobe     = 1'b0;
        busy       = 1'b1;
        unique case (state)
            PH_IDLE:    busy       = 1'b0;
            PH_SETUP:   addr_phase = 1'b1;
            PH_ACTIVE:  strobe     = 1'b1;
            PH_RECOVER: ;
        endcase
        done = done_q;
    end

    assert_start_from_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(addr_phase) |-> !$past(busy));

    assert_strobe_after_setup_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(strobe) |-> $past(addr_phase));

    assert_recovery_gap_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(strobe) |-> (busy && !addr_phase));

    assert_done_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_done_after_recovery_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && $past(busy) && !$past(strobe) && !$past(addr_phase)));

endmodule

// File: rtl/pio_strobe_timer.sv
module pio_strobe_timer
    import pio_timer_pkg::*;
#(
    parameter bit SHARED_SETUP = 1'b0
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_we,
    input  logic [ADDR_W-1:0]   cfg_addr,
    input  logic [TIM_W-1:0]    cfg_wdata,
    input  logic                irq_event,
    input  logic                req,
    input  logic [DRV_W-1:0]    drv_sel,
    output logic                addr_phase,
    output logic                strobe,
    output logic                busy,
    output logic                done,
    output logic                irq_pending
);

    logic [NUM_DRV-1:0][TIM_W-1:0] timing;
    logic [CNT_W-1:0]              setup_clks;

    pio_cfg_regs #(
        .SHARED_SETUP(SHARED_SETUP)
    ) u_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .we           (cfg_we),
        .addr         (cfg_addr),
        .wdata        (cfg_wdata),
        .irq_event    (irq_event),
        .timing_o     (timing),
        .setup_clks_o (setup_clks),
        .pending_o    (irq_pending)
    );

    pio_phase_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .req        (req),
        .drv_sel    (drv_sel),
        .timing     (timing),
        .setup_clks (setup_clks),
        .addr_phase (addr_phase),
        .strobe     (strobe),
        .busy       (busy),
        .done       (done)
    );

endmodule

// File: tb/pio_strobe_timer_tb_top.sv
`timescale 1ns/1ps
module pio_strobe_timer_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_we = 1'b0;
    logic [1:0] cfg_addr = '0;
    logic [7:0] cfg_wdata = '0;
    logic       irq_event = 1'b0;
    logic       req = 1'b0;
    logic       drv_sel = 1'b0;

    logic [1:0] w_addr, w_strobe, w_busy, w_done, w_pend;

    int checks = 0;
    int fails  = 0;
    string scen = "R1";

    always #2.5 clk = ~clk;

    // Instance 0: per-drive setup; instance 1: shared setup.
    pio_strobe_timer #(.SHARED_SETUP(1'b0)) dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .irq_event(irq_event), .req(req), .drv_sel(drv_sel),
        .addr_phase(w_addr[0]), .strobe(w_strobe[0]), .busy(w_busy[0]),
        .done(w_done[0]), .irq_pending(w_pend[0]));

    pio_strobe_timer #(.SHARED_SETUP(1'b1)) dut_sec_i (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .irq_event(irq_event), .req(req), .drv_sel(drv_sel),
        .addr_phase(w_addr[1]), .strobe(w_strobe[1]), .busy(w_busy[1]),
        .done(w_done[1]), .irq_pending(w_pend[1]));

    task automatic check(input bit ok, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s [scenario %s]: actual %0d expected %0d", what, scen, act, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    int m_tim [2][2];
    int m_su  [2][2];
    int m_rs [2], m_ra [2], m_rr [2];
    bit m_done [2], m_pend [2];

    function automatic int su_len(input int code);
        case (code)
            0: return 4;
            1: return 2;
            2: return 3;
            default: return 5;
        endcase
    endfunction

    function automatic int act_len(input int nib);
        if (nib == 0) return 16;
        return nib;
    endfunction

    function automatic int rec_len(input int nib);
        if (nib == 15) return 1;
        if (nib == 0) return 16;
        return nib + 1;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 2; i++) begin
                for (int d = 0; d < 2; d++) begin
                    m_tim[i][d] = 0;
                    m_su[i][d]  = 3;
                end
                m_rs[i] = 0; m_ra[i] = 0; m_rr[i] = 0;
                m_done[i] = 0; m_pend[i] = 0;
            end
        end else begin
            for (int i = 0; i < 2; i++) begin
                if (m_rs[i] + m_ra[i] + m_rr[i] > 0) begin
                    if (m_rs[i] > 0)      m_rs[i]--;
                    else if (m_ra[i] > 0) m_ra[i]--;
                    else                  m_rr[i]--;
                    m_done[i] = (m_rs[i] + m_ra[i] + m_rr[i] == 0);
                end else begin
                    m_done[i] = 0;
                    if (req) begin
                        int t;
                        t = m_tim[i][drv_sel];
                        if (i == 0)
                            m_rs[i] = (su_len(m_su[0][0]) > su_len(m_su[0][1])) ?
                                      su_len(m_su[0][0]) : su_len(m_su[0][1]);
                        else
                            m_rs[i] = su_len(m_su[1][0]);
                        m_ra[i] = act_len(t / 16);
                        m_rr[i] = rec_len(t % 16);
                    end
                end
                if (irq_event) m_pend[i] = 1;
                else if (cfg_we && cfg_addr == 2 && cfg_wdata[4]) m_pend[i] = 0;
                if (cfg_we) begin
                    case (cfg_addr)
                        2'd0: m_tim[i][0] = cfg_wdata;
                        2'd1: m_tim[i][1] = cfg_wdata;
                        2'd2: m_su[i][0] = cfg_wdata[7:6];
                        default: if (i == 0) m_su[i][1] = cfg_wdata[7:6];
                    endcase
                end
            end
        end
    end

    // Per-cycle comparison against the model.
    always @(negedge clk) begin
        if (rst_n) begin
            for (int i = 0; i < 2; i++) begin
                bit ea, es, eb;
                ea = (m_rs[i] > 0);
                es = (m_rs[i] == 0 && m_ra[i] > 0);
                eb = (m_rs[i] + m_ra[i] + m_rr[i] > 0);
                check(w_addr[i] == ea, $sformatf("R3 addr_phase inst%0d", i), w_addr[i], ea);
                check(w_strobe[i] == es, $sformatf("R4 strobe inst%0d", i), w_strobe[i], es);
                check(w_busy[i] == eb, $sformatf("R5 busy inst%0d", i), w_busy[i], eb);
                check(w_done[i] == m_done[i], $sformatf("R6 done inst%0d", i), w_done[i], m_done[i]);
                check(w_pend[i] == m_pend[i], $sformatf("R10 irq_pending inst%0d", i), w_pend[i], m_pend[i]);
            end
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic wr(input int a, input int d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = 2'(a); cfg_wdata = 8'(d);
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic access(input int d, input int es0, input int es1, input int ea, input int er);
        int ns [2], na [2], nr [2], nd [2];
        for (int i = 0; i < 2; i++) begin ns[i] = 0; na[i] = 0; nr[i] = 0; nd[i] = 0; end
        @(negedge clk);
        req = 1'b1; drv_sel = d[0];
        @(negedge clk);
        req = 1'b0;
        for (int k = 0; k < 80; k++) begin
            for (int i = 0; i < 2; i++) begin
                if (w_addr[i]) ns[i]++;
                if (w_strobe[i]) na[i]++;
                if (w_busy[i] && !w_addr[i] && !w_strobe[i]) nr[i]++;
                if (w_done[i]) nd[i]++;
            end
            if (nd[0] > 0 && nd[1] > 0) break;
            @(negedge clk);
        end
        check(ns[0] == es0, "R3/R8 setup clocks inst0", ns[0], es0);
        check(ns[1] == es1, "R3/R9 setup clocks inst1", ns[1], es1);
        for (int i = 0; i < 2; i++) begin
            check(na[i] == ea, $sformatf("R4/R7 active clocks inst%0d", i), na[i], ea);
            check(nr[i] == er, $sformatf("R5/R7 recovery clocks inst%0d", i), nr[i], er);
            check(nd[i] == 1, $sformatf("R6 done pulses inst%0d", i), nd[i], 1);
        end
    endtask

    task automatic count_dones(input int cycles, output int n0, output int n1);
        n0 = 0; n1 = 0;
        for (int k = 0; k < cycles; k++) begin
            @(negedge clk);
            if (w_done[0]) n0++;
            if (w_done[1]) n1++;
        end
    endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (200000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired [scenario %s]: actual 1 expected 0", scen);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    // ---------------- scenarios ----------------
    initial begin
        int n0, n1, nstb;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        scen = "R1";
        for (int i = 0; i < 2; i++) begin
            check(w_addr[i] == 0 && w_strobe[i] == 0, $sformatf("R1 phase outputs idle inst%0d", i),
                  {w_addr[i], w_strobe[i]}, 0);
            check(w_busy[i] == 0 && w_done[i] == 0, $sformatf("R1 busy/done low inst%0d", i),
                  {w_busy[i], w_done[i]}, 0);
            check(w_pend[i] == 0, $sformatf("R1 irq_pending low inst%0d", i), w_pend[i], 0);
        end
        access(0, 5, 5, 16, 16);

        scen = "R4_R5_code15";
        wr(0, 8'h3F);  access(0, 5, 5, 3, 1);
        scen = "R7_drive1";
        wr(1, 8'h01);  access(1, 5, 5, 16, 2);
        scen = "R5_code0";
        wr(0, 8'h10);  access(0, 5, 5, 1, 16);
        scen = "R4_R5_mid";
        wr(0, 8'hE7);  access(0, 5, 5, 14, 8);

        scen = "R3_code01";
        wr(2, 8'h40); wr(3, 8'h40);  access(1, 2, 2, 16, 2);
        scen = "R8_R9_slowest";
        wr(3, 8'hC0);  access(1, 5, 2, 16, 2);
        scen = "R3_R8_codes10_00";
        wr(2, 8'h80); wr(3, 8'h00);  access(0, 4, 3, 14, 8);
        scen = "R8_drive0_slower";
        wr(3, 8'h40);  access(0, 3, 3, 14, 8);

        scen = "R2_held";
        wr(0, 8'h3F); wr(2, 8'h40);
        @(negedge clk);
        req = 1'b1; drv_sel = 1'b0;
        count_dones(21, n0, n1);
        req = 1'b0;
        begin
            int m0, m1;
            count_dones(12, m0, m1);
            n0 += m0; n1 += m1;
        end
        check(n0 == 3, "R2 back-to-back accesses inst0", n0, 3);
        check(n1 == 3, "R2 back-to-back accesses inst1", n1, 3);

        scen = "R2_busy_req";
        @(negedge clk);
        req = 1'b1; drv_sel = 1'b1;
        @(negedge clk);
        req = 1'b0;
        repeat (5) @(negedge clk);
        req = 1'b1;
        @(negedge clk);
        req = 1'b0;
        count_dones(40, n0, n1);
        check(n0 == 1, "R2 request during busy ignored inst0", n0, 1);
        check(n1 == 1, "R2 request during busy ignored inst1", n1, 1);

        scen = "R11_snapshot";
        @(negedge clk);
        req = 1'b1; drv_sel = 1'b0;
        @(negedge clk);
        req = 1'b0;
        nstb = 0;
        if (w_strobe[0]) nstb++;
        cfg_we = 1'b1; cfg_addr = 2'd0; cfg_wdata = 8'h8F;
        @(negedge clk);
        cfg_we = 1'b0;
        for (int k = 0; k < 30; k++) begin
            if (w_strobe[0]) nstb++;
            @(negedge clk);
        end
        check(nstb == 3, "R11 active clocks unchanged by mid-access write", nstb, 3);
        access(0, 2, 2, 8, 1);

        scen = "R10_pending";
        @(negedge clk);
        irq_event = 1'b1;
        @(negedge clk);
        irq_event = 1'b0;
        check(w_pend[0] == 1 && w_pend[1] == 1, "R10 set by irq_event", {w_pend[1], w_pend[0]}, 3);
        wr(2, 8'h40);
        check(w_pend[0] == 1 && w_pend[1] == 1, "R10 kept by setup write bit4=0", {w_pend[1], w_pend[0]}, 3);
        wr(0, 8'h1F);
        check(w_pend[0] == 1 && w_pend[1] == 1, "R10 kept by write to other address", {w_pend[1], w_pend[0]}, 3);
        wr(2, 8'h50);
        check(w_pend[0] == 0 && w_pend[1] == 0, "R10 cleared by bit4 write", {w_pend[1], w_pend[0]}, 0);
        @(negedge clk);
        irq_event = 1'b1; cfg_we = 1'b1; cfg_addr = 2'd2; cfg_wdata = 8'h50;
        @(negedge clk);
        irq_event = 1'b0; cfg_we = 1'b0;
        check(w_pend[0] == 1 && w_pend[1] == 1, "R10 set wins over clear", {w_pend[1], w_pend[0]}, 3);

        repeat (4) @(negedge clk);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule